// File: doc/BRIEF.md
# Word-to-Byte Bus Sizing Bridge

This block lets a 16-bit host with an asynchronous, acknowledge-terminated bus reach an 8-bit peripheral that expects separate active-low read and write strobes. It runs from its own clock, which is unrelated to the host. Each host cycle becomes either one long byte cycle or two short byte cycles that together carry the whole word. Two host control inputs select the mode. They are normally wired to upper host address lines, so that different address windows of the same peripheral give single, double or double-with-register-swap access.

In a two-byte cycle the upper host byte goes first and the lower byte second. For reads, each byte is captured into the matching half of a 16-bit holding register that drives the host data bus. The second register is reached by flipping the low peripheral address bit, not by adding one. Pulse widths and the gap between pulses are counted in clock ticks. The final read strobe stays active until the host ends its cycle. A write strobe ends while the write byte is still driven.

Top module: `bus16to8_bridge`

## Requirements
- R1: After reset, both peripheral strobes and the host acknowledge are high, the peripheral drivers are off, and the read holding register is zero.
- R2: A host cycle is requested when host_as_n and host_ds_n are both low. The request passes two synchronizer flops, so the first strobe goes low after the third rising edge that samples the request. With host_double low, exactly one strobe pulse of SGL_PULSE (13) ticks is produced.
- R3: With host_double high, two strobe pulses of DBL_PULSE (4) ticks are produced, with DBL_GAP (3) ticks of both strobes high between them.
- R4: Byte order is big-endian. In a double cycle, the first byte cycle carries host bits 15:8 and the second carries bits 7:0, for writes and for reads. In a single cycle, the byte uses host bits 7:0, and a single read returns zero in bits 15:8.
- R5: per_addr0 equals host_addr0 during the first byte cycle. In a double cycle with host_consec high, it is inverted for the second cycle (0 then 1, or 1 then 0). With host_consec low, it is unchanged.
- R6: For a write (host_rw low), per_doe is high from the first strobe tick until the host is released. It stays high on the tick after every IOW pulse ends. It is never high during a read.
- R7: During a read (host_rw high), per_din is captured on every tick that IOR is low. The last IOR pulse stays low until the acknowledge is released.
- R8: host_ack_n goes low on the tick after the last pulse reaches its minimum width. It stays low until the host's release has passed the synchronizer, then goes high; IOR ends on that same edge.
- R9: IOR and IOW are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge timing clock, asynchronous to the host |
| rst_n | input | 1 | Synchronous active-low reset |
| host_as_n | input | 1 | Host address strobe, active low |
| host_ds_n | input | 1 | Host data strobe, active low |
| host_rw | input | 1 | 1 = read, 0 = write |
| host_double | input | 1 | Request a two-byte word cycle |
| host_consec | input | 1 | Flip peripheral address bit 0 for the second byte |
| host_addr0 | input | 1 | Low peripheral address bit from the host |
| host_wdata | input | 16 | Host write word |
| host_rdata | output | 16 | Read holding register |
| host_ack_n | output | 1 | Cycle acknowledge to host, active low |
| per_addr0 | output | 1 | Low address bit to the peripheral |
| per_ior_n | output | 1 | Peripheral read strobe, active low |
| per_iow_n | output | 1 | Peripheral write strobe, active low |
| per_doe | output | 1 | Enable for the 8-bit write drivers |
| per_dout | output | 8 | Write byte toward the peripheral |
| per_din | input | 8 | Read byte from the peripheral |

## Verification
The risky overlap is at the end of a read. Read data keeps being captured on the same ticks that the acknowledge is out and the host's release is working through the synchronizer. The last capture and the end of IOR can therefore fall on one edge. The bench provokes this by changing per_din on every tick and by releasing the host either at once or several ticks after the acknowledge. It also starts the next request on the tick right after release, so a new request can arrive in the cycle the bridge returns to idle. A behavioural reference compares strobes, address bit, drivers, acknowledge and holding register against the design on every tick.

// File: rtl/bridge_pkg.sv
// Shared types for the word-to-byte bridge.
// Assumes: used by every module of the bridge; holds no logic.
package bridge_pkg;

    // Transfer phase of the byte sequencer
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PULSE1 = 3'd1,
        ST_GAP    = 3'd2,
        ST_PULSE2 = 3'd3,
        ST_HOLD   = 3'd4
    } bphase_t;

    // Host cycle attributes captured when a transfer starts
    typedef struct packed {
        logic rd;
        logic dbl;
        logic cons;
        logic a0;
    } xfer_ctl_t;

endpackage

// File: rtl/bridge_sync.sv
// Multi-flop synchronizer for host control levels.
// Assumes: each bit is an independent level; STAGES >= 2.
module bridge_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // First flop samples the asynchronous input
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[0] <= '0;
                    else        stg[0] <= d;
                end
            end else begin : g_next
                // Later flops let metastability settle
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[i] <= '0;
                    else        stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/bridge_seq.sv
// Byte-cycle sequencer: turns a synchronized host request into
// a pulse / gap / pulse / hold sequence with tick-counted widths.
// Assumes: host control inputs are stable while the request is active.
module bridge_seq
    import bridge_pkg::*;
#(
    parameter int DBL_PULSE = 4,
    parameter int DBL_GAP   = 3,
    parameter int SGL_PULSE = 13
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_s,
    input  xfer_ctl_t ctl_in,
    output bphase_t   phase,
    output xfer_ctl_t ctl_q,
    output logic      start
);

    localparam int MAX_A  = (SGL_PULSE > DBL_PULSE) ? SGL_PULSE : DBL_PULSE;
    localparam int MAXLEN = (MAX_A > DBL_GAP) ? MAX_A : DBL_GAP;
    localparam int CW     = $clog2(MAXLEN + 1);

    bphase_t       nxt;
    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;
    logic          done;

    // Last tick index of the current timed phase
    always_comb begin
        case (phase)
            ST_PULSE1: limit = CW'(DBL_PULSE - 1);
            ST_GAP:    limit = CW'(DBL_GAP - 1);
            ST_PULSE2: limit = ctl_q.dbl ? CW'(DBL_PULSE - 1) : CW'(SGL_PULSE - 1);
            default:   limit = '0;
        endcase
    end

    assign done  = (cnt == limit);
    assign start = (phase == ST_IDLE) && req_s;

    // Next-phase selection
    always_comb begin
        nxt = phase;
        case (phase)
            ST_IDLE:   if (req_s) nxt = ctl_in.dbl ? ST_PULSE1 : ST_PULSE2;
            ST_PULSE1: if (done)  nxt = ST_GAP;
            ST_GAP:    if (done)  nxt = ST_PULSE2;
            ST_PULSE2: if (done)  nxt = ST_HOLD;
            ST_HOLD:   if (!req_s) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // Phase register, tick counter and captured cycle attributes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= ST_IDLE;
            cnt   <= '0;
            ctl_q <= '0;
        end else begin
            phase <= nxt;
            if (nxt != phase || phase == ST_IDLE || phase == ST_HOLD)
                cnt <= '0;
            else
                cnt <= cnt + 1'b1;
            if (start)
                ctl_q <= ctl_in;
        end
    end

endmodule

// File: rtl/bridge_datapath.sv
// Byte steering, peripheral strobes, address-bit flip and read holding.
// Assumes: phase and ctl come from bridge_seq; wdata stable at start.
module bridge_datapath
    import bridge_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  bphase_t     phase,
    input  xfer_ctl_t   ctl_q,
    input  logic        start,
    input  logic [15:0] wdata,
    input  logic [7:0]  din,
    output logic [15:0] rdata,
    output logic        ack_n,
    output logic        addr0,
    output logic        ior_n,
    output logic        iow_n,
    output logic        doe,
    output logic [7:0]  dout
);

    logic [15:0] wq;
    logic        second;
    logic        pulse;

    // Decode of the current phase into bus controls
    always_comb begin
        second = ctl_q.dbl && (phase == ST_PULSE2 || phase == ST_HOLD);
        pulse  = (phase == ST_PULSE1) || (phase == ST_PULSE2);
        ior_n  = !(ctl_q.rd && (pulse || phase == ST_HOLD));
        iow_n  = !(!ctl_q.rd && pulse);
        doe    = (phase != ST_IDLE) && !ctl_q.rd;
        dout   = (ctl_q.dbl && !second) ? wq[15:8] : wq[7:0];
        addr0  = ctl_q.a0 ^ (second & ctl_q.cons);
        ack_n  = (phase != ST_HOLD);
    end

    // Write word capture and read byte holding
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wq    <= '0;
            rdata <= '0;
        end else if (start) begin
            wq    <= wdata;
            rdata <= '0;
        end else if (!ior_n) begin
            if (ctl_q.dbl && !second) rdata[15:8] <= din;
            else                      rdata[7:0]  <= din;
        end
    end

endmodule

// File: rtl/bus16to8_bridge.sv
// Top of the word-to-byte bridge: synchronizes the host request,
// sequences the byte cycles and steers data to and from the 8-bit side.
// Assumes: host holds rw, double, consec, addr0 and wdata stable while
// its strobes are asserted; clk is the strobe timing reference.
module bus16to8_bridge
    import bridge_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DBL_PULSE   = 4,
    parameter int DBL_GAP     = 3,
    parameter int SGL_PULSE   = 13
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_as_n,
    input  logic        host_ds_n,
    input  logic        host_rw,
    input  logic        host_double,
    input  logic        host_consec,
    input  logic        host_addr0,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    output logic        host_ack_n,
    output logic        per_addr0,
    output logic        per_ior_n,
    output logic        per_iow_n,
    output logic        per_doe,
    output logic [7:0]  per_dout,
    input  logic [7:0]  per_din
);

    logic      req_raw;
    logic      req_s;
    xfer_ctl_t ctl_in;
    xfer_ctl_t ctl_q;
    bphase_t   phase;
    logic      start;

    assign req_raw = !host_as_n && !host_ds_n;
    assign ctl_in  = '{rd: host_rw, dbl: host_double, cons: host_consec, a0: host_addr0};

    bridge_sync #(.STAGES(SYNC_STAGES), .WIDTH(1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(req_raw), .q(req_s)
    );

    bridge_seq #(.DBL_PULSE(DBL_PULSE), .DBL_GAP(DBL_GAP), .SGL_PULSE(SGL_PULSE)) u_seq (
        .clk(clk), .rst_n(rst_n), .req_s(req_s), .ctl_in(ctl_in),
        .phase(phase), .ctl_q(ctl_q), .start(start)
    );

    bridge_datapath u_dp (
        .clk(clk), .rst_n(rst_n), .phase(phase), .ctl_q(ctl_q), .start(start),
        .wdata(host_wdata), .din(per_din), .rdata(host_rdata), .ack_n(host_ack_n),
        .addr0(per_addr0), .ior_n(per_ior_n), .iow_n(per_iow_n),
        .doe(per_doe), .dout(per_dout)
    );

endmodule

// File: rtl/bridge_chk.sv
// Protocol checker for the bridge's peripheral and host-side outputs.
// Assumes: bound to bus16to8_bridge; MIN_PULSE is the shortest legal strobe.
module bridge_chk #(
    parameter int MIN_PULSE = 4
) (
    input logic clk,
    input logic rst_n,
    input logic ior_n,
    input logic iow_n,
    input logic doe,
    input logic ack_n
);

    logic [7:0] low_len;
    logic       strb;

    assign strb = !ior_n || !iow_n;

    // Length of the current or just-ended strobe pulse, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)             low_len <= '0;
        else if (!strb)         low_len <= '0;
        else if (low_len != '1) low_len <= low_len + 1'b1;
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ior_n && !iow_n)); // R9

    AST_WR_DATA_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !iow_n |-> doe); // R6

    AST_IOW_END_DATA_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !iow_n |=> (!iow_n || doe)); // R6

    AST_MIN_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb && low_len != 8'd0) |-> (low_len >= 8'(MIN_PULSE))); // R3

    AST_IOR_HELD_TO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ior_n && !ack_n) |=> (!ior_n || ack_n)); // R7

endmodule

bind bus16to8_bridge bridge_chk #(.MIN_PULSE(DBL_PULSE)) u_chk (
    .clk(clk), .rst_n(rst_n), .ior_n(per_ior_n), .iow_n(per_iow_n),
    .doe(per_doe), .ack_n(host_ack_n)
);

// File: tb/bus16to8_bridge_bench.sv
// Bench: behavioural per-tick reference compared on every falling edge.
module bus16to8_bridge_bench;

    localparam int DP = 4;
    localparam int DG = 3;
    localparam int SP = 13;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        host_as_n = 1, host_ds_n = 1, host_rw = 0;
    logic        host_double = 0, host_consec = 0, host_addr0 = 0;
    logic [15:0] host_wdata = 0;
    logic [15:0] host_rdata;
    logic        host_ack_n, per_addr0, per_ior_n, per_iow_n, per_doe;
    logic [7:0]  per_dout;
    logic [7:0]  per_din = 8'h5A;

    int n_chk = 0, n_fail = 0, cycles = 0;
    bit model_on = 0;

    always #2 clk = ~clk;

    bus16to8_bridge #(.SYNC_STAGES(2), .DBL_PULSE(DP), .DBL_GAP(DG), .SGL_PULSE(SP)) u_bus16to8_bridge (
        .clk(clk), .rst_n(rst_n), .host_as_n(host_as_n), .host_ds_n(host_ds_n),
        .host_rw(host_rw), .host_double(host_double), .host_consec(host_consec),
        .host_addr0(host_addr0), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_ack_n(host_ack_n), .per_addr0(per_addr0), .per_ior_n(per_ior_n),
        .per_iow_n(per_iow_n), .per_doe(per_doe), .per_dout(per_dout), .per_din(per_din)
    );

    // Reference model state
    bit m_busy, m_rd, m_dbl, m_cons, m_a0, m_s1, m_s2;
    int m_t;
    logic [15:0] m_w, m_rdat;

    function automatic int m_end();
        return m_dbl ? (2 * DP + DG) : SP;
    endfunction

    function automatic bit m_pulse(int t);
        if (m_dbl) return (t < DP) || (t >= DP + DG && t < 2 * DP + DG);
        return t < SP;
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Model update at each rising edge, from bench-driven values only
    always @(posedge clk) begin
        bit req_raw, hold;
        cycles++;
        req_raw = !host_as_n && !host_ds_n;
        if (!rst_n) begin
            m_busy = 0; m_rd = 0; m_dbl = 0; m_cons = 0; m_a0 = 0;
            m_s1 = 0; m_s2 = 0; m_t = 0; m_w = 0; m_rdat = 0;
        end else begin
            if (!m_busy) begin
                if (m_s2) begin
                    m_busy = 1; m_t = 0; m_rd = host_rw; m_dbl = host_double;
                    m_cons = host_consec; m_a0 = host_addr0; m_w = host_wdata; m_rdat = 0;
                end
            end else begin
                hold = (m_t >= m_end());
                if (m_rd && (hold || m_pulse(m_t))) begin
                    if (m_dbl && m_t < DP + DG) m_rdat[15:8] = per_din;
                    else                        m_rdat[7:0]  = per_din;
                end
                if (hold && !m_s2) m_busy = 0;
                else if (!hold)    m_t++;
            end
            m_s2 = m_s1; m_s1 = req_raw;
        end
    end

    // Per-tick comparison and data-in churn on the falling edge
    always @(negedge clk) begin
        bit hold, act, second;
        string rq;
        if (model_on) begin
            hold   = m_busy && (m_t >= m_end());
            act    = m_busy && (hold || m_pulse(m_t));
            second = m_busy && m_dbl && (m_t >= DP + DG);
            rq     = m_dbl ? "R3" : "R2";
            chk({rq, " IOR"}, per_ior_n, !(m_rd && act));
            chk({rq, " IOW"}, per_iow_n, !(m_busy && !m_rd && m_pulse(m_t) && !hold));
            chk("R9 one strobe", per_ior_n | per_iow_n, 1'b1);
            chk("R5 addr0", per_addr0, m_a0 ^ (second & m_cons));
            chk("R6 doe", per_doe, m_busy && !m_rd);
            if (m_busy && !m_rd)
                chk("R4 write byte", per_dout, (m_dbl && !second) ? m_w[15:8] : m_w[7:0]);
            chk("R8 ack", host_ack_n, !hold);
            chk(m_rd ? "R7 read hold" : "R4 read hold", host_rdata, m_rdat);
        end
        per_din <= per_din + 8'h1D;
    end

    // Watchdog: expiry counts as a failure and still reaches the summary
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    task automatic host_cycle(bit rd, bit dbl, bit cons, bit a0, logic [15:0] w, int extra);
        @(negedge clk);
        host_rw = rd; host_double = dbl; host_consec = cons; host_addr0 = a0;
        host_wdata = w; host_as_n = 0; host_ds_n = 0;
        while (host_ack_n) @(negedge clk);
        repeat (extra) @(negedge clk);
        host_as_n = 1; host_ds_n = 1;
        while (!host_ack_n) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 ior", per_ior_n, 1'b1);
        chk("R1 iow", per_iow_n, 1'b1);
        chk("R1 ack", host_ack_n, 1'b1);
        chk("R1 doe", per_doe, 1'b0);
        chk("R1 rdata", host_rdata, 16'h0000);
        rst_n = 1;
        model_on = 1;
        // R2 / R4: single write and single read
        host_cycle(0, 0, 0, 1, 16'hA55A, 0);
        host_cycle(1, 0, 0, 0, 16'h0000, 2);
        // R3 / R5: double writes, flip from 0 and from 1, and no flip
        host_cycle(0, 1, 1, 0, 16'h1234, 0);
        host_cycle(0, 1, 1, 1, 16'hBEEF, 1);
        host_cycle(0, 1, 0, 1, 16'hC3E1, 0);
        // R7 / R4: double reads with long and immediate host release
        host_cycle(1, 1, 1, 0, 16'h0000, 6);
        host_cycle(1, 1, 1, 1, 16'h0000, 0);
        host_cycle(1, 1, 0, 0, 16'h0000, 3);
        // R8: back-to-back cycles with no idle gap
        for (int i = 0; i < 4; i++)
            host_cycle(bit'(i[0]), bit'(i[1]), 1, bit'(i[0]), 16'(16'h0F0F * (i + 1)), 0);
        repeat (6) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule